// File: doc/BRIEF.md
# PHY Lane Configuration Sequencer

This block brings a combined USB3/PCIe PHY lane into USB3 operation after reset. On a start pulse it walks a fixed, ordered script of eight steps. Three steps update fields in directly mapped PHY control words. The block keeps a shadow copy of each of those words and writes the whole word, so only the named fields change. Five steps are read-modify-write operations on internal PHY registers, reached through a request port to a separate control-bus master. Each of these reads a register, merges the read data with a clear mask and a set pattern, and writes the result back to the same address.

The bus master does the low-level capture and acknowledge handshake. The sequencer only presents one request at a time and waits for its completion. If any bus operation reports an error, the script stops on the spot and an error flag is raised. A later start clears that flag and runs the script again from the first step.

Top module: `phy_cfg_seq`

## Requirements
- R1: A start pulse while idle (or stopped on error) raises busy_o on the next cycle, and the first step runs in that cycle. A start while busy has no effect: the script is not restarted, and no extra request or direct write appears after it.
- R2: Step one is a direct write to word 0 (dreg_sel_o = 0). It holds the shadow value with bits 6:5 forced to 2'b11 and every other bit unchanged.
- R3: The bus steps run in this order: 0x102D, 0x1010, 0x1006, 0x1002, 0x0030. Each is a read (req_op_o = 0) followed by a write (req_op_o = 1) to the same address. No request appears outside this order.
- R4: The write to 0x102D is the read data with bit 7 set. The write to 0x1010 is the read data with bits 11:4 cleared and then ORed with 0x0014.
- R5: The write to 0x1006 has bit 6 = 0, bit 7 = 1, bits 10:8 = 3 and bit 11 = 1. The write to 0x1002 has bits 13:7 = 22, bits 6:0 = 0x7F and bit 14 = 1. All other bits of both come from the read data.
- R6: The write to 0x0030 is the read data with bits 7:4 replaced by 8.
- R7: After the bus steps come two direct writes. The first goes to word 2 (sel 2) with bits 20:18 = 4. The second goes to word 1 (sel 1) with bits 23:21 = 4 and bits 20:16 = 9. All other bits keep their shadow values.
- R8: done_o is high for exactly one cycle, the cycle after the final direct write. busy_o is low in that cycle.
- R9: A response with rsp_err_i high stops the script. From the next cycle err_o is high and busy_o is low, and no further request or direct write is issued. The next accepted start clears err_o.
- R10: A request (req_valid_o with address, op and write data) stays unchanged until req_ready_i. A response (rsp_done_i with rsp_rdata_i and rsp_err_i) counts only after the request has been accepted.
- R11: After reset busy_o, done_o, err_o, req_valid_o and dreg_we_o are low. The shadows hold the reset-value parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start the script |
| busy_o | output | 1 | Script in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Script stopped by a bus error |
| req_valid_o | output | 1 | Bus request valid |
| req_ready_i | input | 1 | Bus master accepts the request |
| req_op_o | output | 1 | 0 = read, 1 = write |
| req_addr_o | output | 16 | Internal register address |
| req_wdata_o | output | 16 | Write data |
| rsp_done_i | input | 1 | Bus operation completed |
| rsp_err_i | input | 1 | Completion carries an error |
| rsp_rdata_i | input | 16 | Read data, valid with rsp_done_i |
| dreg_we_o | output | 1 | Direct word write strobe |
| dreg_sel_o | output | 2 | Direct word index (0, 1, 2) |
| dreg_wdata_o | output | 32 | Full direct word value |

## Verification
A wrong step index or a wrong state shows up at once at the ports. The next request carries the wrong address or op, or a direct write appears with the wrong index, and either is caught on the cycle the request or write is presented. A wrong merge, or a stale captured read value, shows in the data of the very next bus write. A corrupted shadow shows in the data of the next direct write to that word, which may come only on a later run. An error that is not latched shows within one request: another request or direct write appears after the failing response.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

    localparam int CR_AW     = 16;
    localparam int CR_DW     = 16;
    localparam int DREG_W    = 32;
    localparam int DREG_NUM  = 3;
    localparam int DSEL_W    = $clog2(DREG_NUM);
    localparam int NUM_STEPS = 8;
    localparam int IDX_W     = $clog2(NUM_STEPS);
    localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(NUM_STEPS - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR,
        ST_RD,
        ST_RDW,
        ST_WR,
        ST_WRW,
        ST_ERR
    } state_e;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    typedef struct packed {
        logic              is_dir;
        logic [DSEL_W-1:0] sel;
        logic [CR_AW-1:0]  addr;
        logic [DREG_W-1:0] clr;
        logic [DREG_W-1:0] set;
    } step_t;

    typedef struct packed {
        state_e           st;
        logic [IDX_W-1:0] idx;
        logic [CR_DW-1:0] data;
        logic             err;
        logic             done;
    } ctl_t;

endpackage

// File: rtl/phy_cfg_step_rom.sv
module phy_cfg_step_rom
    import phy_cfg_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    output step_t            step_o
);

    function automatic step_t mk_dir(input int unsigned sel, input logic [DREG_W-1:0] clr,
                                     input logic [DREG_W-1:0] set);
        step_t s;
        s.is_dir = 1'b1;
        s.sel    = DSEL_W'(sel);
        s.addr   = '0;
        s.clr    = clr;
        s.set    = set;
        return s;
    endfunction

    function automatic step_t mk_bus(input logic [CR_AW-1:0] addr, input logic [CR_DW-1:0] clr,
                                     input logic [CR_DW-1:0] set);
        step_t s;
        s.is_dir = 1'b0;
        s.sel    = '0;
        s.addr   = addr;
        s.clr    = DREG_W'(clr);
        s.set    = DREG_W'(set);
        return s;
    endfunction

    always_comb begin
        case (idx_i)
            3'd0:    step_o = mk_dir(0, 32'h0000_0060, 32'h0000_0060);
            3'd1:    step_o = mk_bus(16'h102D, 16'h0080, 16'h0080);
            3'd2:    step_o = mk_bus(16'h1010, 16'h0FF0, 16'h0014);
            3'd3:    step_o = mk_bus(16'h1006, 16'h0FC0, 16'h0B80);
            3'd4:    step_o = mk_bus(16'h1002, 16'h3F80, 16'h4B7F);
            3'd5:    step_o = mk_bus(16'h0030, 16'h00F0, 16'h0080);
            3'd6:    step_o = mk_dir(2, 32'h001C_0000, 32'h0010_0000);
            default: step_o = mk_dir(1, 32'h00FF_0000, 32'h0089_0000);
        endcase
    end

endmodule

// File: rtl/phy_cfg_merge.sv
module phy_cfg_merge #(
    parameter int W = 16
) (
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] data_o
);

    always_comb begin
        data_o = (data_i & ~clr_i) | set_i;
    end

endmodule

// File: rtl/phy_cfg_shadow.sv
module phy_cfg_shadow #(
    parameter int                  NUM   = 3,
    parameter int                  W     = 32,
    parameter logic [NUM*W-1:0]    RST_V = '0,
    localparam int                 SW    = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [SW-1:0] sel_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o
);

    logic [W-1:0] word_q [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_word
        logic [W-1:0] word_d;

        always_comb begin
            word_d = word_q[g];
            if (we_i && (sel_i == SW'(g))) begin
                word_d = wdata_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                word_q[g] <= RST_V[g*W +: W];
            end else begin
                word_q[g] <= word_d;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM; i++) begin
            if (sel_i == SW'(i)) begin
                rdata_o = word_q[i];
            end
        end
    end

endmodule

// File: rtl/phy_cfg_seq.sv
module phy_cfg_seq
    import phy_cfg_pkg::*;
#(
    parameter logic [DREG_W-1:0] RST_DREG0 = 32'h0000_0000,
    parameter logic [DREG_W-1:0] RST_DREG1 = 32'h0000_0000,
    parameter logic [DREG_W-1:0] RST_DREG2 = 32'h0000_0000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic              req_op_o,
    output logic [CR_AW-1:0]  req_addr_o,
    output logic [CR_DW-1:0]  req_wdata_o,
    input  logic              rsp_done_i,
    input  logic              rsp_err_i,
    input  logic [CR_DW-1:0]  rsp_rdata_i,
    output logic              dreg_we_o,
    output logic [DSEL_W-1:0] dreg_sel_o,
    output logic [DREG_W-1:0] dreg_wdata_o
);

    ctl_t             ctl_q, ctl_d;
    step_t            cur_step, nxt_step;
    logic [IDX_W-1:0] nxt_idx;
    logic             at_rest;
    logic [CR_DW-1:0] bus_merged;
    logic [DREG_W-1:0] shadow_rd, dir_merged;

    assign at_rest = (ctl_q.st == ST_IDLE) || (ctl_q.st == ST_ERR);
    assign nxt_idx = at_rest ? '0 : ctl_q.idx + 1'b1;

    phy_cfg_step_rom u_rom_cur (
        .idx_i  (ctl_q.idx),
        .step_o (cur_step)
    );

    phy_cfg_step_rom u_rom_nxt (
        .idx_i  (nxt_idx),
        .step_o (nxt_step)
    );

    phy_cfg_merge #(.W(CR_DW)) u_merge_bus (
        .data_i (rsp_rdata_i),
        .clr_i  (cur_step.clr[CR_DW-1:0]),
        .set_i  (cur_step.set[CR_DW-1:0]),
        .data_o (bus_merged)
    );

    phy_cfg_merge #(.W(DREG_W)) u_merge_dir (
        .data_i (shadow_rd),
        .clr_i  (cur_step.clr),
        .set_i  (cur_step.set),
        .data_o (dir_merged)
    );

    phy_cfg_shadow #(
        .NUM   (DREG_NUM),
        .W     (DREG_W),
        .RST_V ({RST_DREG2, RST_DREG1, RST_DREG0})
    ) u_shadow (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (dreg_we_o),
        .sel_i   (cur_step.sel),
        .wdata_i (dir_merged),
        .rdata_o (shadow_rd)
    );

    function automatic state_e entry_state(input step_t s);
        return s.is_dir ? ST_DIR : ST_RD;
    endfunction

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE, ST_ERR: begin
                if (start_i) begin
                    ctl_d.err = 1'b0;
                    ctl_d.idx = nxt_idx;
                    ctl_d.st  = entry_state(nxt_step);
                end
            end
            ST_DIR: begin
                if (ctl_q.idx == LAST_STEP) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.idx  = '0;
                    ctl_d.done = 1'b1;
                end else begin
                    ctl_d.idx = nxt_idx;
                    ctl_d.st  = entry_state(nxt_step);
                end
            end
            ST_RD: begin
                if (req_ready_i) begin
                    ctl_d.st = ST_RDW;
                end
            end
            ST_RDW: begin
                if (rsp_done_i) begin
                    if (rsp_err_i) begin
                        ctl_d.err = 1'b1;
                        ctl_d.st  = ST_ERR;
                    end else begin
                        ctl_d.data = bus_merged;
                        ctl_d.st   = ST_WR;
                    end
                end
            end
            ST_WR: begin
                if (req_ready_i) begin
                    ctl_d.st = ST_WRW;
                end
            end
            ST_WRW: begin
                if (rsp_done_i) begin
                    if (rsp_err_i) begin
                        ctl_d.err = 1'b1;
                        ctl_d.st  = ST_ERR;
                    end else if (ctl_q.idx == LAST_STEP) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.idx  = '0;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.idx = nxt_idx;
                        ctl_d.st  = entry_state(nxt_step);
                    end
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{st: ST_IDLE, idx: '0, data: '0, err: 1'b0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        busy_o       = !at_rest;
        done_o       = ctl_q.done;
        err_o        = ctl_q.err;
        req_valid_o  = (ctl_q.st == ST_RD) || (ctl_q.st == ST_WR);
        req_op_o     = (ctl_q.st == ST_WR) ? OP_WRITE : OP_READ;
        req_addr_o   = cur_step.addr;
        req_wdata_o  = (ctl_q.st == ST_WR) ? ctl_q.data : '0;
        dreg_we_o    = (ctl_q.st == ST_DIR);
        dreg_sel_o   = cur_step.sel;
        dreg_wdata_o = dir_merged;
    end

endmodule

// File: rtl/phy_cfg_seq_chk.sv
module phy_cfg_seq_chk
    import phy_cfg_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic              req_op_o,
    input logic [CR_AW-1:0]  req_addr_o,
    input logic [CR_DW-1:0]  req_wdata_o,
    input logic              dreg_we_o,
    input logic [DSEL_W-1:0] dreg_sel_o
);

    p_start_runs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o);

    p_first_word0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> (dreg_we_o && dreg_sel_o == '0));

    p_one_target_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_valid_o && dreg_we_o));

    p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    p_err_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (!busy_o && !req_valid_o && !dreg_we_o));

    p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (!req_valid_o && !dreg_we_o));

    p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_o && !req_ready_i) |=>
            (req_valid_o && $stable(req_addr_o) && $stable(req_op_o) && $stable(req_wdata_o)));

endmodule

bind phy_cfg_seq phy_cfg_seq_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_op_o    (req_op_o),
    .req_addr_o  (req_addr_o),
    .req_wdata_o (req_wdata_o),
    .dreg_we_o   (dreg_we_o),
    .dreg_sel_o  (dreg_sel_o)
);

// File: tb/phy_cfg_seq_bench.sv
module phy_cfg_seq_bench;

    localparam logic [31:0] RV0 = 32'h0000_0010;
    localparam logic [31:0] RV1 = 32'hA5A5_A5A5;
    localparam logic [31:0] RV2 = 32'h0F0F_0F0F;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic        busy_o, done_o, err_o;
    logic        req_valid_o;
    logic        req_ready_i = 1'b0;
    logic        req_op_o;
    logic [15:0] req_addr_o, req_wdata_o;
    logic        rsp_done_i = 1'b0;
    logic        rsp_err_i = 1'b0;
    logic [15:0] rsp_rdata_i = 16'hBEEF;
    logic        dreg_we_o;
    logic [1:0]  dreg_sel_o;
    logic [31:0] dreg_wdata_o;

    always #5 clk_i = ~clk_i;

    phy_cfg_seq #(.RST_DREG0(RV0), .RST_DREG1(RV1), .RST_DREG2(RV2)) u_phy_cfg_seq (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_op_o(req_op_o),
        .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
        .rsp_done_i(rsp_done_i), .rsp_err_i(rsp_err_i), .rsp_rdata_i(rsp_rdata_i),
        .dreg_we_o(dreg_we_o), .dreg_sel_o(dreg_sel_o), .dreg_wdata_o(dreg_wdata_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // expected event stream: kind 0 = bus read, 1 = bus write, 2 = direct write
    int          ek[$];
    int          ea[$];
    logic [31:0] ed[$];

    logic [15:0] mem [int];
    logic [31:0] sh [3];
    int lat_cfg = 0, dly_cfg = 0, err_at = -1, txn_cnt = 0, done_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] f_bus(input int a, input logic [15:0] d);
        logic [15:0] r = d;
        case (a)
            'h102D: r[7] = 1'b1;
            'h1010: begin r[11:4] = 8'h00; r = r | 16'h0014; end
            'h1006: begin r[6] = 1'b0; r[7] = 1'b1; r[10:8] = 3'd3; r[11] = 1'b1; end
            'h1002: begin r[13:7] = 7'd22; r[6:0] = 7'h7F; r[14] = 1'b1; end
            default: r[7:4] = 4'd8;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input int a);
        if (a == 'h102D || a == 'h1010) return "R4";
        if (a == 'h1006 || a == 'h1002) return "R5";
        return "R6";
    endfunction

    task automatic plan_run();
        int addrs[5] = '{'h102D, 'h1010, 'h1006, 'h1002, 'h0030};
        logic [31:0] w;
        ek.delete(); ea.delete(); ed.delete();
        w = sh[0]; w[6:5] = 2'b11;
        ek.push_back(2); ea.push_back(0); ed.push_back(w);
        foreach (addrs[i]) begin
            ek.push_back(0); ea.push_back(addrs[i]); ed.push_back(0);
            ek.push_back(1); ea.push_back(addrs[i]);
            ed.push_back({16'h0, f_bus(addrs[i], mem[addrs[i]])});
        end
        w = sh[2]; w[20:18] = 3'd4;
        ek.push_back(2); ea.push_back(2); ed.push_back(w);
        w = sh[1]; w[23:21] = 3'd4; w[20:16] = 5'd9;
        ek.push_back(2); ea.push_back(1); ed.push_back(w);
        txn_cnt = 0;
    endtask

    // bus responder and per-transaction comparison
    initial begin
        int phase = 0, dly = 0, lat = 0;
        logic cur_op;
        int cur_a;
        logic [15:0] cur_w;
        forever begin
            @(negedge clk_i);
            case (phase)
                0: begin
                    if (req_valid_o) begin
                        if (dly > 0) dly--;
                        else begin
                            req_ready_i = 1'b1;
                            cur_op = req_op_o; cur_a = int'(req_addr_o); cur_w = req_wdata_o;
                            if (ek.size() == 0 || ek[0] == 2) begin
                                chk(0, "R3", "unexpected bus request addr", {16'h0, req_addr_o}, 0);
                            end else begin
                                chk(int'(req_op_o) == ek[0], "R3", "op", {31'h0, req_op_o}, ek[0]);
                                chk(int'(req_addr_o) == ea[0], "R3", "address", {16'h0, req_addr_o}, ea[0]);
                                if (ek[0] == 1)
                                    chk({16'h0, req_wdata_o} == ed[0], tag_of(ea[0]), "write data",
                                        {16'h0, req_wdata_o}, ed[0]);
                                void'(ek.pop_front()); void'(ea.pop_front()); void'(ed.pop_front());
                            end
                            lat = lat_cfg;
                            phase = 1;
                        end
                    end
                end
                1: begin
                    req_ready_i = 1'b0;
                    if (lat > 0) lat--;
                    else begin
                        rsp_done_i = 1'b1;
                        rsp_err_i = (txn_cnt == err_at);
                        rsp_rdata_i = (cur_op == 1'b0) ? mem[cur_a] : 16'hBEEF;
                        if (cur_op == 1'b1 && txn_cnt != err_at) mem[cur_a] = cur_w;
                        txn_cnt++;
                        dly = dly_cfg;
                        phase = 2;
                    end
                end
                default: begin
                    rsp_done_i = 1'b0; rsp_err_i = 1'b0; rsp_rdata_i = 16'hBEEF;
                    phase = 0;
                end
            endcase
        end
    end

    // per-cycle monitor of direct writes and status outputs
    initial begin
        bit prev_done = 0;
        forever begin
            @(negedge clk_i);
            if (rst_ni) begin
                if (dreg_we_o) begin
                    if (ek.size() == 0 || ek[0] != 2) begin
                        chk(0, "R7", "unexpected direct write", dreg_wdata_o, 0);
                    end else begin
                        string t = (ea[0] == 0) ? "R2" : "R7";
                        chk(int'(dreg_sel_o) == ea[0], t, "direct index", {30'h0, dreg_sel_o}, ea[0]);
                        chk(dreg_wdata_o == ed[0], t, "direct data", dreg_wdata_o, ed[0]);
                        void'(ek.pop_front()); void'(ea.pop_front()); void'(ed.pop_front());
                    end
                    sh[dreg_sel_o] = dreg_wdata_o;
                end
                if (done_o) begin
                    done_cnt++;
                    if (busy_o) chk(0, "R8", "busy with done", 1, 0);
                    if (prev_done) chk(0, "R8", "done longer than one cycle", 1, 0);
                end
                if (err_o && (busy_o || req_valid_o || dreg_we_o))
                    chk(0, "R9", "activity while in error", 1, 0);
                prev_done = done_o;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog run did not end actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk_i); start_i = 1'b1;
        @(negedge clk_i); start_i = 1'b0;
    endtask

    task automatic full_run(input string note);
        int dc = done_cnt;
        int n = 0;
        plan_run();
        pulse_start();
        chk(busy_o == 1'b1, "R1", {note, " busy after start"}, busy_o, 1);
        chk(err_o == 1'b0, "R9", {note, " error cleared by start"}, err_o, 0);
        while (!done_o && n < 2000) begin @(negedge clk_i); n++; end
        chk(done_o == 1'b1, "R8", {note, " done seen"}, done_o, 1);
        chk(ek.size() == 0, "R8", {note, " all steps before done"}, ek.size(), 0);
        @(negedge clk_i);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R8", {note, " done single cycle"}, done_o, 0);
        chk(done_cnt == dc + 1, "R8", {note, " one done per run"}, done_cnt, dc + 1);
    endtask

    task automatic err_run(input int at, input int left, input string note);
        int n = 0;
        int dc = done_cnt;
        err_at = at;
        plan_run();
        pulse_start();
        while (!err_o && n < 2000) begin @(negedge clk_i); n++; end
        repeat (20) @(negedge clk_i);
        chk(err_o == 1'b1, "R9", {note, " error flag"}, err_o, 1);
        chk(busy_o == 1'b0, "R9", {note, " not busy"}, busy_o, 0);
        chk(ek.size() == left, "R9", {note, " steps left unissued"}, ek.size(), left);
        chk(done_cnt == dc, "R9", {note, " no done"}, done_cnt, dc);
        err_at = -1;
    endtask

    initial begin
        sh[0] = RV0; sh[1] = RV1; sh[2] = RV2;
        repeat (3) @(negedge clk_i);
        chk(busy_o == 0, "R11", "reset busy", busy_o, 0);
        chk(done_o == 0, "R11", "reset done", done_o, 0);
        chk(err_o == 0, "R11", "reset err", err_o, 0);
        chk(req_valid_o == 0, "R11", "reset req_valid", req_valid_o, 0);
        chk(dreg_we_o == 0, "R11", "reset dreg_we", dreg_we_o, 0);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);

        // run 1: immediate handshake, start pulsed again while busy (R1)
        mem['h102D] = 16'h1234; mem['h1010] = 16'hFFFF; mem['h1006] = 16'h0000;
        mem['h1002] = 16'hFFFF; mem['h0030] = 16'h5A5A;
        lat_cfg = 0; dly_cfg = 0;
        fork
            full_run("run1");
            begin
                repeat (4) @(negedge clk_i);
                start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
            end
        join
        repeat (10) @(negedge clk_i);
        chk(ek.size() == 0 && busy_o == 0, "R1", "start while busy ignored", busy_o, 0);

        // run 2: slow bus, other data patterns, shadows carried from run 1
        mem['h102D] = 16'h0000; mem['h1010] = 16'h0000; mem['h1006] = 16'hFFFF;
        mem['h1002] = 16'h0000; mem['h0030] = 16'hFFFF;
        lat_cfg = 3; dly_cfg = 2;
        full_run("run2");

        // error on the read of 0x1006 (bus txn 4): 13 - 6 steps remain
        mem['h1006] = 16'hC3C3;
        lat_cfg = 1; dly_cfg = 1;
        err_run(4, 7, "err_read");
        // error on the write of 0x0030 (txn 9): both trailing direct writes withheld
        err_run(9, 2, "err_write");

        // recovery run after error
        lat_cfg = 0; dly_cfg = 3;
        full_run("recover");
        repeat (30) @(negedge clk_i);
        chk(busy_o == 0 && ek.size() == 0, "R3", "quiet after completion", busy_o, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule